// File: doc/BRIEF.md
# Read-Modify-Write Memory Sequencer

This block carries out one read-modify-write instruction against a byte-wide memory port. A start command captures an operation code, a base address, the accumulator, the incoming carry and negative flags, and a width select. The sequencer reads the operand (one byte in narrow mode, two bytes in wide mode) and then spends one cycle with neither strobe active. It writes the modified value back to the same location and publishes new carry, zero and negative flags together with an open-bus latch.

Eight operations share one engine: shift left, logical shift right, rotate left and right through carry, increment, decrement, and two bit-test operations that set or clear the accumulator's bits in memory. The memory is treated as combinational on reads: `mem_rdata_i` must show the byte at `mem_addr_o` in the same cycle that `mem_rd_o` is high. A write takes effect at the clock edge that ends a cycle with `mem_wr_o` high.

Top module: `rmw_seq`

## Requirements
- R1: After the operand reads the sequencer spends exactly one cycle with both strobes low, then writes. `busy_o` is high for exactly 3 cycles in narrow mode and 5 cycles in wide mode.
- R2: When `narrow_i` is 0 (wide), the low byte is read at the base address and then the high byte at base+1. The high byte is written back at base+1 first, then the low byte at base. base+1 wraps modulo 2^AW.
- R3: `op_i`=0 shifts left, putting 0 in bit 0 and the old top bit of the active width in carry. `op_i`=1 shifts right, putting 0 in the top bit and old bit 0 in carry.
- R4: `op_i`=2 rotates left, putting the captured carry in bit 0 and the old top bit in carry. `op_i`=3 rotates right, putting the captured carry in the top bit and old bit 0 in carry.
- R5: `op_i`=4 adds one and `op_i`=5 subtracts one, both wrapping at the active width. `carry_o` equals the captured `carry_i`.
- R6: `op_i`=6 writes memory OR accumulator and `op_i`=7 writes memory AND NOT accumulator. For both, `zero_o` is 1 exactly when memory AND accumulator is 0 over the active width, `neg_o` equals the captured `neg_i`, and `carry_o` equals the captured `carry_i`.
- R7: `narrow_i`=1 selects 8 bits and `narrow_i`=0 selects 16 bits. For ops 0 to 5, `neg_o` is the top bit of the active-width result and `zero_o` is 1 when that result is 0. In narrow mode the byte at base+1 is left untouched.
- R8: From the cycle `done_o` is high, `obus_o` holds the low byte of the value written, and the flags hold the new values until the next operation completes.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last write. In that cycle `busy_o` is already low.
- R10: `start_i` is ignored while `busy_o` is high. No extra access or operation results from it.
- R11: After reset, `busy_o`, `done_o`, both strobes, all flags and `obus_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command, sampled while idle |
| op_i | input | 3 | Operation code (0..7, see R3 to R6) |
| narrow_i | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| addr_i | input | AW | Base address of the operand |
| acc_i | input | 16 | Accumulator value for the bit-test operations |
| carry_i | input | 1 | Incoming carry flag |
| neg_i | input | 1 | Incoming negative flag |
| mem_addr_o | output | AW | Memory address |
| mem_rdata_i | input | 8 | Memory read data, valid in the strobe cycle |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Result carry flag |
| zero_o | output | 1 | Result zero flag |
| neg_o | output | 1 | Result negative flag |
| obus_o | output | 8 | Open-bus latch |

## Verification
The bench builds the block with AW=8, which gives a 256-byte memory model. With that width, a wide operation at base 0xFF reaches its high byte at address 0x00, so the base+1 wrap of R2 is exercised directly. The narrow width checks the untouched neighbour byte at base+1. At the wide width, every operation is checked with carries across the byte boundary, such as 0x00FF+1 and 0x0000-1.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / BYTE_W;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_ROL  = 3'd2,
    OP_ROR  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_TSET = 3'd6,
    OP_TCLR = 3'd7
  } rmw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD_LO = 3'd1,
    ST_RD_HI = 3'd2,
    ST_GAP   = 3'd3,
    ST_WR_HI = 3'd4,
    ST_WR_LO = 3'd5
  } rmw_st_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
  } rmw_flags_t;
endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    narrow_i,
  output rmw_st_e state_o,
  output logic    accept_o,
  output logic    narrow_o
);
  rmw_st_e state_q, state_d;
  logic    narrow_q;

  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_RD_LO;
      ST_RD_LO: state_d = narrow_q ? ST_GAP : ST_RD_HI;
      ST_RD_HI: state_d = ST_GAP;
      ST_GAP:   state_d = narrow_q ? ST_WR_LO : ST_WR_HI;
      ST_WR_HI: state_d = ST_WR_LO;
      ST_WR_LO: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      narrow_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (accept_o) narrow_q <= narrow_i;
    end
  end

  assign state_o  = state_q;
  assign narrow_o = narrow_q;

  // R1: the idle cycle only ever follows a read
  a_r1_gap_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> ($past(state_q) == ST_RD_LO || $past(state_q) == ST_RD_HI));

  // R10: a start seen while busy never restarts the read phase
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> (state_q != ST_RD_LO));
endmodule

// File: rtl/rmw_opnd.sv
module rmw_opnd
  import rmw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  ld_i,
  input  logic              clr_up_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DATA_W-1:0] value_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 lane_q <= '0;
      else if (ld_i[g])            lane_q <= byte_i;
      else if (clr_up_i && g != 0) lane_q <= '0;
    end
    assign value_o[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
(
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] acc_i,
  input  rmw_op_e           op_i,
  input  logic              narrow_i,
  input  logic              c_i,
  input  logic              n_i,
  output logic [DATA_W-1:0] res_o,
  output rmw_flags_t        flags_o
);
  localparam logic [DATA_W-1:0] NMASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [DATA_W-1:0] NTOP  = DATA_W'(1) << (BYTE_W - 1);
  localparam logic [DATA_W-1:0] WTOP  = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] mask, opm, accm, raw, top_bit;
  logic              top_in, top_res, bit_test;

  always_comb begin
    mask     = narrow_i ? NMASK : '1;
    top_bit  = narrow_i ? NTOP : WTOP;
    opm      = opnd_i & mask;
    accm     = acc_i & mask;
    top_in   = |(opm & top_bit);
    bit_test = (op_i == OP_TSET) || (op_i == OP_TCLR);
    flags_o.c = c_i;
    raw       = opm;
    unique case (op_i)
      OP_SHL:  begin raw = opm << 1;                     flags_o.c = top_in; end
      OP_SHR:  begin raw = opm >> 1;                     flags_o.c = opm[0]; end
      OP_ROL:  begin raw = (opm << 1) | DATA_W'(c_i);    flags_o.c = top_in; end
      OP_ROR:  begin raw = (opm >> 1) | (c_i ? top_bit : '0); flags_o.c = opm[0]; end
      OP_INC:  raw = opm + 1'b1;
      OP_DEC:  raw = opm - 1'b1;
      OP_TSET: raw = opm | accm;
      OP_TCLR: raw = opm & ~accm;
      default: raw = opm;
    endcase
    res_o     = raw & mask;
    top_res   = |(res_o & top_bit);
    flags_o.z = bit_test ? ((opm & accm) == '0) : (res_o == '0);
    flags_o.n = bit_test ? n_i : top_res;
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic              narrow_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              carry_i,
  input  logic              neg_i,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic [BYTE_W-1:0] obus_o
);
  rmw_st_e           state;
  logic              accept, narrow;
  logic [AW-1:0]     base_q;
  logic [DATA_W-1:0] acc_q, opnd, alu_res, res_q;
  rmw_op_e           op_q;
  logic              cin_q, nin_q, done_q;
  rmw_flags_t        alu_flags, stage_q, flags_q;
  logic [BYTE_W-1:0] obus_q;
  logic [LANES-1:0]  ld;

  rmw_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .narrow_i (narrow_i),
    .state_o  (state),
    .accept_o (accept),
    .narrow_o (narrow)
  );

  assign ld = {state == ST_RD_HI, state == ST_RD_LO};

  rmw_opnd u_opnd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld),
    .clr_up_i (state == ST_RD_LO),
    .byte_i   (mem_rdata_i),
    .value_o  (opnd)
  );

  rmw_alu u_alu (
    .opnd_i   (opnd),
    .acc_i    (acc_q),
    .op_i     (op_q),
    .narrow_i (narrow),
    .c_i      (cin_q),
    .n_i      (nin_q),
    .res_o    (alu_res),
    .flags_o  (alu_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      acc_q   <= '0;
      op_q    <= OP_SHL;
      cin_q   <= 1'b0;
      nin_q   <= 1'b0;
      res_q   <= '0;
      stage_q <= '0;
      flags_q <= '0;
      obus_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        base_q <= addr_i;
        acc_q  <= acc_i;
        op_q   <= rmw_op_e'(op_i);
        cin_q  <= carry_i;
        nin_q  <= neg_i;
      end
      if (state == ST_GAP) begin
        res_q   <= alu_res;
        stage_q <= alu_flags;
      end
      if (state == ST_WR_LO) begin
        flags_q <= stage_q;
        obus_q  <= res_q[BYTE_W-1:0];
        done_q  <= 1'b1;
      end
    end
  end

  assign mem_rd_o    = (state == ST_RD_LO) || (state == ST_RD_HI);
  assign mem_wr_o    = (state == ST_WR_HI) || (state == ST_WR_LO);
  assign mem_addr_o  = ((state == ST_RD_HI) || (state == ST_WR_HI)) ? base_q + 1'b1 : base_q;
  assign mem_wdata_o = (state == ST_WR_HI) ? res_q[DATA_W-1:BYTE_W] : res_q[BYTE_W-1:0];
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = done_q;
  assign carry_o     = flags_q.c;
  assign zero_o      = flags_q.z;
  assign neg_o       = flags_q.n;
  assign obus_o      = obus_q;

  // R1: the first write of an operation follows a cycle with no strobe
  a_r1_gap_before_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_wr_o) |-> $past(busy_o && !mem_rd_o));

  a_r1_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o}));

  // R9: completion is a single pulse right after the last write
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(mem_wr_o)));

  // R8: open-bus latch equals the last byte driven on the write bus
  a_r8_obus_last_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (obus_o == $past(mem_wdata_o)));

  // R5: increment and decrement pass the captured carry through
  a_r5_carry_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_INC || op_q == OP_DEC)) |-> (carry_o == cin_q));

  // R6: bit-test operations keep the captured negative flag
  a_r6_neg_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_TSET || op_q == OP_TCLR)) |-> (neg_o == nin_q));
endmodule

// File: tb/rmw_seq_tb.sv
module rmw_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] op = '0;
  logic       narrow = 1'b1;
  logic [7:0] addr = '0;
  logic [15:0] acc = '0;
  logic       cin = 1'b0, nin = 1'b0;
  logic [7:0] mem_addr, mem_rdata, mem_wdata, obus;
  logic       mem_rd, mem_wr, busy, done, c_o, z_o, n_o;
  logic [7:0] mem [256];

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rmw_seq #(.AW(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .narrow_i(narrow),
    .addr_i(addr), .acc_i(acc), .carry_i(cin), .neg_i(nin),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .busy_o(busy), .done_o(done),
    .carry_o(c_o), .zero_o(z_o), .neg_o(n_o), .obus_o(obus)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  typedef struct {
    string      req;
    logic [7:0] a;
    logic       nar;
    logic [7:0] lo, hi;
    logic       c, z, n;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // independent reference from the requirement text
  task automatic model(input logic [2:0] o, input logic nr, input int v, input int ac,
                       input logic ci, input logic ni,
                       output int r, output logic c, output logic z, output logic n);
    int msk, top;
    msk = nr ? 'hFF : 'hFFFF;
    top = nr ? 'h80 : 'h8000;
    v = v & msk; ac = ac & msk;
    c = ci; r = v;
    case (o)
      0: begin r = v * 2;                     c = (v & top) != 0; end
      1: begin r = v / 2;                     c = v[0]; end
      2: begin r = v * 2 + int'(ci);          c = (v & top) != 0; end
      3: begin r = v / 2 + (ci ? top : 0);    c = v[0]; end
      4: r = v + 1;
      5: r = v + msk;
      6: r = v | ac;
      7: r = v & ~ac;
      default: r = v;
    endcase
    r = r & msk;
    if (o >= 6) begin z = (v & ac) == 0; n = ni; end
    else begin z = (r == 0); n = (r & top) != 0; end
  endtask

  // monitor: access trace and scoreboard pop
  int         tk[8];
  logic [7:0] ta[8];
  int         tn = 0;
  always @(negedge clk) begin
    if (rst_n && busy) begin
      if (tn < 8) begin
        tk[tn] = (mem_rd && mem_wr) ? 3 : mem_rd ? 1 : mem_wr ? 2 : 0;
        ta[tn] = mem_addr;
      end
      tn++;
    end
    if (rst_n && done) begin
      if (q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
      else begin
        exp_t e;
        logic [7:0] a1;
        e = q.pop_front();
        a1 = e.a + 8'd1;
        chk(tn == (e.nar ? 3 : 5), "R1", "busy cycles", tn, e.nar ? 3 : 5);
        if (e.nar && tn == 3) begin
          chk(tk[0] == 1 && ta[0] == e.a, "R1", "read", tk[0], 1);
          chk(tk[1] == 0, "R1", "gap", tk[1], 0);
          chk(tk[2] == 2 && ta[2] == e.a, "R1", "write", tk[2], 2);
        end else if (!e.nar && tn == 5) begin
          chk(tk[0] == 1 && ta[0] == e.a, "R2", "read lo", ta[0], e.a);
          chk(tk[1] == 1 && ta[1] == a1,  "R2", "read hi", ta[1], a1);
          chk(tk[2] == 0, "R1", "gap", tk[2], 0);
          chk(tk[3] == 2 && ta[3] == a1,  "R2", "write hi", ta[3], a1);
          chk(tk[4] == 2 && ta[4] == e.a, "R2", "write lo", ta[4], e.a);
        end
        chk(mem[e.a] == e.lo, e.req, "mem lo", mem[e.a], e.lo);
        chk(mem[a1] == e.hi, e.nar ? "R7" : e.req, "mem hi", mem[a1], e.hi);
        chk(c_o == e.c, e.req, "carry", c_o, e.c);
        chk(z_o == e.z, e.req, "zero", z_o, e.z);
        chk(n_o == e.n, e.req, "neg", n_o, e.n);
        chk(obus == e.lo, "R8", "obus", obus, e.lo);
      end
      tn = 0;
    end
  end

  task automatic run_op(input string req, input logic [2:0] o, input logic nr,
                        input logic [7:0] a, input logic [15:0] v, input logic [15:0] ac,
                        input logic ci, input logic ni, input bit inject);
    exp_t e;
    int r;
    logic [7:0] a1;
    a1 = a + 8'd1;
    @(negedge clk);
    mem[a] = v[7:0];
    mem[a1] = v[15:8];
    model(o, nr, int'(v), int'(ac), ci, ni, r, e.c, e.z, e.n);
    e.req = req; e.a = a; e.nar = nr;
    e.lo = r[7:0];
    e.hi = nr ? v[15:8] : r[15:8];
    q.push_back(e);
    op = o; narrow = nr; addr = a; acc = ac; cin = ci; nin = ni; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      // R10: stray start while busy, aimed elsewhere
      mem[8'h40] = 8'h5A;
      op = 3'd6; addr = 8'h40; acc = 16'h00FF; narrow = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done, "R9", "done width", done, 0);
    chk(!busy, "R9", "busy after done", busy, 0);
    if (inject) begin
      @(negedge clk);
      chk(!busy && q.size() == 0, "R10", "no extra op", busy, 0);
      chk(mem[8'h40] == 8'h5A, "R10", "stray target", mem[8'h40], 8'h5A);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R11", "ctrl reset", busy, 0);
    chk(!c_o && !z_o && !n_o && obus == 0, "R11", "flag reset", obus, 0);
    rst_n = 1'b1;

    // narrow
    run_op("R3", 3'd0, 1, 8'h10, 16'hC381, 16'h0, 0, 0, 0);
    run_op("R3", 3'd1, 1, 8'h12, 16'h7701, 16'h0, 0, 1, 0);
    run_op("R4", 3'd2, 1, 8'h14, 16'h1180, 16'h0, 1, 0, 0);
    run_op("R4", 3'd3, 1, 8'h16, 16'h2201, 16'h0, 1, 0, 0);
    run_op("R4", 3'd3, 1, 8'h18, 16'h2240, 16'h0, 0, 1, 0);
    run_op("R5", 3'd4, 1, 8'h1A, 16'h33FF, 16'h0, 1, 0, 0);
    run_op("R5", 3'd5, 1, 8'h1C, 16'h4400, 16'h0, 0, 0, 0);
    run_op("R6", 3'd6, 1, 8'h1E, 16'h550F, 16'hAAF0, 1, 1, 0);
    run_op("R6", 3'd7, 1, 8'h20, 16'h66FF, 16'h000F, 0, 0, 0);
    run_op("R7", 3'd0, 1, 8'h22, 16'hFF40, 16'h0, 0, 0, 0);
    // wide
    run_op("R3", 3'd0, 0, 8'h30, 16'h8001, 16'h0, 0, 0, 0);
    run_op("R3", 3'd1, 0, 8'h32, 16'h0100, 16'h0, 1, 0, 0);
    run_op("R4", 3'd2, 0, 8'h34, 16'h4080, 16'h0, 1, 0, 0);
    run_op("R4", 3'd3, 0, 8'h36, 16'h0001, 16'h0, 1, 0, 0);
    run_op("R5", 3'd4, 0, 8'h38, 16'h00FF, 16'h0, 1, 1, 0);
    run_op("R5", 3'd5, 0, 8'h3A, 16'h0000, 16'h0, 0, 0, 0);
    run_op("R5", 3'd4, 0, 8'h3C, 16'hFFFF, 16'h0, 0, 1, 0);
    run_op("R6", 3'd6, 0, 8'h50, 16'h0F00, 16'hF0F0, 0, 1, 0);
    run_op("R6", 3'd7, 0, 8'h52, 16'hFF00, 16'h0F0F, 1, 0, 0);
    run_op("R2", 3'd5, 0, 8'hFF, 16'h1200, 16'h0, 0, 0, 0);
    // start while busy
    run_op("R10", 3'd4, 1, 8'h60, 16'h0009, 16'h0, 0, 0, 1);
    run_op("R10", 3'd2, 0, 8'h62, 16'h8000, 16'h0, 0, 0, 1);
    // sweep
    begin
      logic [31:0] s;
      s = 32'h1234_5678;
      for (int k = 0; k < 64; k++) begin
        s = s * 32'd1664525 + 32'd1013904223;
        run_op("R7", s[2:0], s[3], {s[11:5], 1'b0} + 8'h80, s[31:16], s[27:12],
               s[4], s[12], 0);
      end
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule